// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers every interrupt condition of a FIFO-based UART and reports the single most urgent one through an 8-bit identification byte and one request line. It watches the receive FIFO fill level and a receive-timeout strobe. It also watches the transmit FIFO empty flag, event pulses from the line-status and modem-status logic, and read strobes for the status registers. It keeps sticky flags for the event-driven sources and combines them with a 5-bit enable vector and a fixed priority order.

The block also holds the FIFO control register. That register carries the FIFO-mode enable, the unit enable, the receive trigger selection and two self-clearing flush commands. The flush commands leave the block as one-cycle pulses for the FIFOs. The FIFOs, the shifters and the bus decoder sit outside the block. They drive its strobes and consume its flush pulses.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01 and `fcr_rdata`, `irq`, `rx_flush` and `tx_flush` are all 0.
- R2: A write to the FIFO control register stores every bit except bits 1 and 2, which always read back 0. Bit 0 is FIFO mode, bit 4 is unit enable and bits 7:6 are the trigger select.
- R3: A write with bit 1 set gives exactly one `rx_flush` pulse in the cycle after the write. A write with bit 2 set does the same on `tx_flush`.
- R4: Identification bits 7:6 read 11 in FIFO mode and 00 otherwise. Bits 5:4 always read 0.
- R5: Identification bit 0 reads 0 while any enabled source is pending and 1 when none is. With nothing pending, bits 3:1 read 000.
- R6: Bits 3:1 carry the source code: 3 for line status, 2 for receive data or timeout, 1 for transmit empty and 0 for modem status. When several sources are pending, the code follows that order, from line status (highest) to modem status (lowest).
- R7: With enable bit 0 set, receive data is pending while `rx_level` is at or above the trigger. In FIFO mode the trigger select values 0,1,2,3 give triggers of 1,4,8,15. In non-FIFO mode the trigger is 1.
- R8: A `rx_timeout` strobe latches a timeout that reports code 2 when enable bit 4 is set. The latch clears on `rx_rd` or on a receive flush pulse.
- R9: Any nonzero `ls_evt` latches a line-status condition (enable bit 2). `lsr_rd` clears it, and `isr_rd` leaves it alone.
- R10: Any nonzero `ms_evt` latches a modem condition (enable bit 3). `msr_rd` clears it, and `isr_rd` leaves it alone.
- R11: The transmit-empty condition (enable bit 1) is latched when `tx_empty` rises, or when enable bit 1 rises while `tx_empty` is high. It clears on `tx_wr`, or on `isr_rd` while code 1 is the reported source. A set and a clear in the same cycle leave it set.
- R12: `irq` is high exactly when bit 0 reads 0 and the unit enable is 1. It stays low while the unit enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 5 | Enables: 0 rx data, 1 tx empty, 2 line, 3 modem, 4 timeout |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| fcr_rdata | output | 8 | FIFO control read-back |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| tx_flush | output | 1 | One-cycle transmit FIFO flush |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_rd | input | 1 | Receive data read strobe |
| rx_timeout | input | 1 | Receive timeout strobe |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_wr | input | 1 | Transmit data write strobe |
| ls_evt | input | EVT_W | Line error event pulses |
| lsr_rd | input | 1 | Line status read strobe |
| ms_evt | input | EVT_W | Modem change event pulses |
| msr_rd | input | 1 | Modem status read strobe |
| isr_rd | input | 1 | Identification byte read strobe |
| isr | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench probes each trigger select exactly one entry below and at its threshold. An off-by-one compare would show up as a request that comes one entry early or late. It also checks that non-FIFO mode falls back to a threshold of 1, even with trigger bits set. It stacks all four sources and removes them one at a time. An encoder with the order wrong would report the wrong code at some step. The bench reads the identification byte while a higher source hides transmit-empty, and a design that clears on every read would drop that flag. Last, it checks that flush bits read back 0 and pulse for a single cycle, and that the request stays low while the unit is disabled.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   typedef enum logic [1:0] {
      SRC_MODEM  = 2'd0,
      SRC_TXE    = 2'd1,
      SRC_RXDATA = 2'd2,
      SRC_LINE   = 2'd3
   } src_code_e;

   localparam int FCR_FIFO_BIT  = 0;
   localparam int FCR_RXFL_BIT  = 1;
   localparam int FCR_TXFL_BIT  = 2;
   localparam int FCR_UNIT_BIT  = 4;
   localparam int FCR_TRIG_LSB  = 6;

   localparam int EN_RX   = 0;
   localparam int EN_TXE  = 1;
   localparam int EN_LINE = 2;
   localparam int EN_MDM  = 3;
   localparam int EN_TMO  = 4;

   localparam int NUM_LATCH = 4;
   localparam int LT_LINE = 0;
   localparam int LT_MDM  = 1;
   localparam int LT_TMO  = 2;
   localparam int LT_TXE  = 3;
endpackage

// File: rtl/uirq_fcr.sv
module uirq_fcr
   import uirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       fifo_mode,
   output logic       unit_en,
   output logic [1:0] trig_sel,
   output logic       rx_flush,
   output logic       tx_flush
);
   localparam logic [7:0] FLUSH_MASK = (8'd1 << FCR_RXFL_BIT) | (8'd1 << FCR_TXFL_BIT);

   logic [7:0] ctl_q;
   logic       rxf_q, txf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         rxf_q <= 1'b0;
         txf_q <= 1'b0;
      end else begin
         rxf_q <= wr & wdata[FCR_RXFL_BIT];
         txf_q <= wr & wdata[FCR_TXFL_BIT];
         if (wr) ctl_q <= wdata & ~FLUSH_MASK;
      end
   end

   assign rdata     = ctl_q;
   assign fifo_mode = ctl_q[FCR_FIFO_BIT];
   assign unit_en   = ctl_q[FCR_UNIT_BIT];
   assign trig_sel  = ctl_q[FCR_TRIG_LSB +: 2];
   assign rx_flush  = rxf_q;
   assign tx_flush  = txf_q;
endmodule

// File: rtl/uirq_trigger.sv
module uirq_trigger #(
   parameter int LVL_W  = 5,
   parameter int TRIG_0 = 1,
   parameter int TRIG_1 = 4,
   parameter int TRIG_2 = 8,
   parameter int TRIG_3 = 15
) (
   input  logic [LVL_W-1:0] level,
   input  logic             fifo_mode,
   input  logic [1:0]       sel,
   output logic             reached
);
   localparam int LVL_MAX = (1 << LVL_W) - 1;

   generate
      if (LVL_W < 1)
         $error("uirq_trigger: LVL_W must be at least 1");
      if (TRIG_0 < 1 || TRIG_0 > LVL_MAX || TRIG_1 > LVL_MAX ||
          TRIG_2 > LVL_MAX || TRIG_3 > LVL_MAX)
         $error("uirq_trigger: trigger levels must fit in LVL_W bits");
   endgenerate

   localparam logic [LVL_W-1:0] T0 = LVL_W'(TRIG_0);
   localparam logic [LVL_W-1:0] T1 = LVL_W'(TRIG_1);
   localparam logic [LVL_W-1:0] T2 = LVL_W'(TRIG_2);
   localparam logic [LVL_W-1:0] T3 = LVL_W'(TRIG_3);
   localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

   logic [LVL_W-1:0] thresh;

   always_comb begin
      if (!fifo_mode) begin
         thresh = ONE;
      end else begin
         unique case (sel)
            2'd0:    thresh = T0;
            2'd1:    thresh = T1;
            2'd2:    thresh = T2;
            default: thresh = T3;
         endcase
      end
   end

   assign reached = (level >= thresh);
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uirq_pkg::*;
#(
   parameter int LVL_W  = 5,
   parameter int EVT_W  = 4,
   parameter int TRIG_0 = 1,
   parameter int TRIG_1 = 4,
   parameter int TRIG_2 = 8,
   parameter int TRIG_3 = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       ier,
   input  logic             fcr_wr,
   input  logic [7:0]       fcr_wdata,
   output logic [7:0]       fcr_rdata,
   output logic             rx_flush,
   output logic             tx_flush,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_rd,
   input  logic             rx_timeout,
   input  logic             tx_empty,
   input  logic             tx_wr,
   input  logic [EVT_W-1:0] ls_evt,
   input  logic             lsr_rd,
   input  logic [EVT_W-1:0] ms_evt,
   input  logic             msr_rd,
   input  logic             isr_rd,
   output logic [7:0]       isr,
   output logic             irq
);
   generate
      if (EVT_W < 1)
         $error("uart_irq_ident: EVT_W must be at least 1");
   endgenerate

   logic       fifo_mode, unit_en;
   logic [1:0] trig_sel;
   logic       rx_reached;

   uirq_fcr u_fcr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (fcr_wr),
      .wdata     (fcr_wdata),
      .rdata     (fcr_rdata),
      .fifo_mode (fifo_mode),
      .unit_en   (unit_en),
      .trig_sel  (trig_sel),
      .rx_flush  (rx_flush),
      .tx_flush  (tx_flush)
   );

   uirq_trigger #(
      .LVL_W  (LVL_W),
      .TRIG_0 (TRIG_0),
      .TRIG_1 (TRIG_1),
      .TRIG_2 (TRIG_2),
      .TRIG_3 (TRIG_3)
   ) u_trig (
      .level     (rx_level),
      .fifo_mode (fifo_mode),
      .sel       (trig_sel),
      .reached   (rx_reached)
   );

   // edge history for transmit-empty detection
   logic txe_prev_q, txe_en_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe_prev_q    <= 1'b0;
         txe_en_prev_q <= 1'b0;
      end else begin
         txe_prev_q    <= tx_empty;
         txe_en_prev_q <= ier[EN_TXE];
      end
   end

   logic            any_pend;
   src_code_e       code;
   logic [NUM_LATCH-1:0] lt_set, lt_clr, lt_q;

   always_comb begin
      lt_set          = '0;
      lt_clr          = '0;
      lt_set[LT_LINE] = |ls_evt;
      lt_clr[LT_LINE] = lsr_rd;
      lt_set[LT_MDM]  = |ms_evt;
      lt_clr[LT_MDM]  = msr_rd;
      lt_set[LT_TMO]  = rx_timeout;
      lt_clr[LT_TMO]  = rx_rd | rx_flush;
      lt_set[LT_TXE]  = (tx_empty & ~txe_prev_q) |
                        (tx_empty & ier[EN_TXE] & ~txe_en_prev_q);
      lt_clr[LT_TXE]  = tx_wr | (isr_rd & any_pend & (code == SRC_TXE));
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LATCH; gi++) begin : g_src
         uirq_sticky u_lt (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (lt_set[gi]),
            .clr   (lt_clr[gi]),
            .q     (lt_q[gi])
         );
      end
   endgenerate

   logic p_line, p_rx, p_txe, p_mdm;
   assign p_line = ier[EN_LINE] & lt_q[LT_LINE];
   assign p_rx   = (ier[EN_RX] & rx_reached) | (ier[EN_TMO] & lt_q[LT_TMO]);
   assign p_txe  = ier[EN_TXE] & lt_q[LT_TXE];
   assign p_mdm  = ier[EN_MDM] & lt_q[LT_MDM];

   always_comb begin
      any_pend = p_line | p_rx | p_txe | p_mdm;
      if (p_line)     code = SRC_LINE;
      else if (p_rx)  code = SRC_RXDATA;
      else if (p_txe) code = SRC_TXE;
      else            code = SRC_MODEM;
   end

   assign isr = {{2{fifo_mode}}, 2'b00, 1'b0,
                 (any_pend ? code : SRC_MODEM), ~any_pend};
   assign irq = unit_en & any_pend;
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
   parameter int LVL_W = 5,
   parameter int EVT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [4:0]       ier,
   input logic             fcr_wr,
   input logic [7:0]       fcr_wdata,
   input logic [7:0]       fcr_rdata,
   input logic             rx_flush,
   input logic             tx_flush,
   input logic [EVT_W-1:0] ls_evt,
   input logic [7:0]       isr,
   input logic             irq
);
   assert_flush_rd0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_rdata[2:1] == 2'b00);

   assert_rxflush_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_wr && fcr_wdata[1]) |=> rx_flush);

   assert_txflush_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flush && !$past(fcr_wr)) |-> 1'b0);

   assert_mode_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (isr[7:6] == {2{fcr_rdata[0]}}) && (isr[5:4] == 2'b00));

   assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      isr[0] |-> (isr[3:1] == 3'd0));

   assert_line_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[2] && (ls_evt != '0)) ##1 ier[2] |-> (isr[3:1] == 3'd3));

   assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!isr[0] && fcr_rdata[4]));
endmodule

bind uart_irq_ident uirq_checker #(.LVL_W(LVL_W), .EVT_W(EVT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ier       (ier),
   .fcr_wr    (fcr_wr),
   .fcr_wdata (fcr_wdata),
   .fcr_rdata (fcr_rdata),
   .rx_flush  (rx_flush),
   .tx_flush  (tx_flush),
   .ls_evt    (ls_evt),
   .isr       (isr),
   .irq       (irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
   localparam int LVL_W = 5;
   localparam int EVT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] ier = '0;
   logic fcr_wr = 1'b0;
   logic [7:0] fcr_wdata = '0;
   logic [7:0] fcr_rdata;
   logic rx_flush, tx_flush;
   logic [LVL_W-1:0] rx_level = '0;
   logic rx_rd = 1'b0, rx_timeout = 1'b0, tx_empty = 1'b0, tx_wr = 1'b0;
   logic [EVT_W-1:0] ls_evt = '0, ms_evt = '0;
   logic lsr_rd = 1'b0, msr_rd = 1'b0, isr_rd = 1'b0;
   logic [7:0] isr;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ident #(.LVL_W(LVL_W), .EVT_W(EVT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ier(ier), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
      .fcr_rdata(fcr_rdata), .rx_flush(rx_flush), .tx_flush(tx_flush),
      .rx_level(rx_level), .rx_rd(rx_rd), .rx_timeout(rx_timeout),
      .tx_empty(tx_empty), .tx_wr(tx_wr), .ls_evt(ls_evt), .lsr_rd(lsr_rd),
      .ms_evt(ms_evt), .msr_rd(msr_rd), .isr_rd(isr_rd), .isr(isr), .irq(irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic write_fcr(logic [7:0] v);
      fcr_wr = 1'b1; fcr_wdata = v;
      step();
      fcr_wr = 1'b0; fcr_wdata = '0;
   endtask

   task automatic t_reset();
      chk("R1 isr", isr, 8'h01);
      chk("R1 fcr", fcr_rdata, 8'h00);
      chk("R1 irq/flush", {5'd0, irq, rx_flush, tx_flush}, 8'h00);
   endtask

   task automatic t_fcr();
      write_fcr(8'hD7);
      chk("R2 readback", fcr_rdata, 8'hD1);
      chk("R3 flush pulse", {6'd0, rx_flush, tx_flush}, 8'h03);
      chk("R4 fifo bits", isr, 8'hC1);
      step();
      chk("R3 flush single", {6'd0, rx_flush, tx_flush}, 8'h00);
      write_fcr(8'h53);
      chk("R3 rx only", {6'd0, rx_flush, tx_flush}, 8'h02);
      chk("R2 readback2", fcr_rdata, 8'h51);
      step();
   endtask

   task automatic t_trigger();
      ier = 5'b00001;
      for (int s = 0; s < 4; s++) begin
         int t;
         t = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 15;
         write_fcr({s[1:0], 6'b010001});
         rx_level = LVL_W'(t - 1); step();
         chk("R7 below trigger", isr, 8'hC1);
         rx_level = LVL_W'(t); step();
         chk("R7 at trigger", isr, 8'hC4);
         chk("R12 irq", {7'd0, irq}, 8'h01);
      end
      write_fcr(8'hD0);
      rx_level = 5'd0; step();
      chk("R4 non-fifo idle", isr, 8'h01);
      rx_level = 5'd1; step();
      chk("R7 non-fifo trigger 1", isr, 8'h04);
      rx_level = 5'd0;
      write_fcr(8'h11);
      step();
   endtask

   task automatic t_timeout();
      ier = 5'b10000;
      rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
      chk("R8 timeout code", isr, 8'hC4);
      step();
      chk("R8 timeout held", isr, 8'hC4);
      rx_rd = 1'b1; step(); rx_rd = 1'b0;
      chk("R8 cleared by read", isr, 8'hC1);
      rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
      write_fcr(8'h13);
      step();
      chk("R8 cleared by flush", isr, 8'hC1);
   endtask

   task automatic t_line_modem();
      ier = 5'b01100;
      ms_evt = 4'b0100; step(); ms_evt = '0;
      chk("R10 modem code", isr, 8'hC0);
      ls_evt = 4'b0010; step(); ls_evt = '0;
      chk("R9 line code", isr, 8'hC6);
      isr_rd = 1'b1; step(); isr_rd = 1'b0;
      chk("R9 isr read keeps line", isr, 8'hC6);
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      chk("R9 cleared by lsr read", isr, 8'hC0);
      isr_rd = 1'b1; step(); isr_rd = 1'b0;
      chk("R10 isr read keeps modem", isr, 8'hC0);
      msr_rd = 1'b1; step(); msr_rd = 1'b0;
      chk("R10 cleared by msr read", isr, 8'hC1);
   endtask

   task automatic t_txe();
      ier = 5'b00010;
      tx_empty = 1'b1; step();
      chk("R11 set on rise", isr, 8'hC2);
      tx_wr = 1'b1; step(); tx_wr = 1'b0;
      chk("R11 cleared by write", isr, 8'hC1);
      ier = 5'b00000; step();
      ier = 5'b00010; step();
      chk("R11 set on enable rise", isr, 8'hC2);
      isr_rd = 1'b1; step(); isr_rd = 1'b0;
      chk("R11 cleared by isr read", isr, 8'hC1);
      tx_empty = 1'b0; step();
   endtask

   task automatic t_priority();
      ier = 5'b01111;
      write_fcr(8'h11);
      ms_evt = 4'b0001; ls_evt = 4'b1000; rx_level = 5'd1; tx_empty = 1'b1;
      step();
      ms_evt = '0; ls_evt = '0;
      chk("R6 line first", isr, 8'hC6);
      isr_rd = 1'b1; step(); isr_rd = 1'b0;
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      chk("R6 rx second", isr, 8'hC4);
      rx_level = 5'd0; step();
      chk("R11 hidden txe kept", isr, 8'hC2);
      isr_rd = 1'b1; step(); isr_rd = 1'b0;
      chk("R6 modem last", isr, 8'hC0);
      write_fcr(8'h01);
      chk("R12 irq gated", {7'd0, irq}, 8'h00);
      chk("R12 pending still shown", isr, 8'hC0);
      write_fcr(8'h11);
      chk("R12 irq back", {7'd0, irq}, 8'h01);
      msr_rd = 1'b1; step(); msr_rd = 1'b0;
      chk("R5 none pending", isr, 8'hC1);
      chk("R5 irq low", {7'd0, irq}, 8'h00);
      tx_empty = 1'b0; step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_fcr();
      t_trigger();
      t_timeout();
      t_line_modem();
      t_txe();
      t_priority();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule